// File: doc/BRIEF.md
# Dual-Channel Serial Result Readout

This block lets a host shift out two result registers of an oversampling converter over two independent serial channels. Channel A holds the decimated (filtered) 32-bit code. It captures that code only when the filter delivers a new output, and it appends an 8-bit tag that tells the host which decimation ratio is in force, so that channel A sends a 40-bit frame. Channel B holds a 22-bit composite word that is reloaded on every conversion. The word carries a 14-bit differential field followed by an 8-bit common-mode field. Both channels send two's complement data, MSB first.

Each channel has an active-low read enable and its own serial clock. The serial clocks and enables are sampled in the block's system clock domain. A rising serial-clock edge that is seen while the channel is enabled advances that channel's bit pointer by one. The block does not drive pads itself. For each channel it gives a data bit and an output-enable bit, and the pad driver places the line in high impedance when the enable is low. Channel A's pointer is kept while the channel is disabled and while channel B reloads. A slow host can therefore read the filtered word a bit or a few bits per conversion.

Each channel runs a two-state machine. SHIFT means bits remain to be sent. LAST means the pointer sits on the LSB. The named transitions are:
- reload: any state to SHIFT, with the pointer at the MSB.
- advance: SHIFT to SHIFT, moving the pointer one bit toward the LSB.
- finish: SHIFT to LAST, taken on the edge that reaches the LSB.
- hold: LAST to LAST on further edges.

When both channels are enabled together, a conflict flag rises. If the parameter that marks the two data lines as sharing one wire is set, channel A keeps the line and channel B's enable is withheld.

Top module: `serial_result_port`

## Requirements
- R1: After reset both pointers sit at the MSB of all-zero registers. With a read enable low, the channel's data bit is 0.
- R2: A channel's output-enable is high exactly while its active-low read enable is low, except for channel B in the conflict case of R11.
- R3: Channel A sends frame bits 39 down to 0, one per enabled serial-clock rising edge. Bits 39..32 are code bits 31..24, bits 31..8 are the rest of the code, and bits 7..0 are the tag.
- R4: The tag is 8'h00, 8'h01, 8'h02 or 8'h03 for a decimation-select input of 0, 1, 2 or 3 (ratio 256, 1024, 4096 or 16384). It is captured together with the code.
- R5: Channel A's register changes only in a cycle where load_a is high. Changes on code_a or df_sel at other times have no effect on the bits sent.
- R6: Channel A's bit pointer is kept while rd_a_n is high and while channel B reloads. A read split into several bursts continues at the next bit.
- R7: A load sets the channel's pointer to the MSB, and the new MSB is on the data bit in the cycle after the load.
- R8: After the LSB has been reached, further serial-clock edges leave the LSB on the data bit.
- R9: Channel B sends a 22-bit frame, MSB first: diff_b bits 13..0, then cm_b bits 7..0.
- R10: Serial-clock edges that arrive while a channel's read enable is high do not move its pointer.
- R11: While both read enables are low, conflict is 1. When the lines are shared, sdo_b_en is 0 and channel A stays driven.
- R12: If a load and an enabled serial-clock edge fall in the same cycle, the load wins and the pointer is at the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| code_a | input | 32 | Filtered code to capture |
| df_sel | input | 2 | Decimation ratio select, 0..3 |
| load_a | input | 1 | New filtered output ready, captures code_a and tag |
| rd_a_n | input | 1 | Channel A read enable, active low |
| sck_a | input | 1 | Channel A serial clock |
| diff_b | input | 14 | Differential field of composite word |
| cm_b | input | 8 | Common-mode field of composite word |
| load_b | input | 1 | Conversion done, captures composite word |
| rd_b_n | input | 1 | Channel B read enable, active low |
| sck_b | input | 1 | Channel B serial clock |
| sdo_a | output | 1 | Channel A data bit |
| sdo_a_en | output | 1 | Channel A line drive enable |
| sdo_b | output | 1 | Channel B data bit |
| sdo_b_en | output | 1 | Channel B line drive enable |
| conflict | output | 1 | Both channels enabled at once |

## Verification
Channel A is swept over all four decimation selects. Each select is paired with a different code: one with only the end bits set, an irregular mixed pattern, the most positive value and all ones. A bit-order error, a misplaced tag or a wrong tag value then shows up as a bit mismatch at a known frame position. Channel B is read with three pairs of fields, chosen so that swapped fields or a reversed bit order give different streams. Split reads, edges during disable, a load that collides with an edge, and reads past the LSB separate pointer bookkeeping faults from data faults.

// File: rtl/sr_pkg.sv
package sr_pkg;
    localparam int CODE_W = 32;
    localparam int TAG_W  = 8;
    localparam int DIFF_W = 14;
    localparam int CM_W   = 8;
    localparam int SEL_W  = 2;

    typedef enum logic {
        CH_SHIFT = 1'b0,
        CH_LAST  = 1'b1
    } chan_state_e;
endpackage

// File: rtl/sr_tag_enc.sv
module sr_tag_enc #(
    parameter int SEL_W = 2,
    parameter int TAG_W = 8
) (
    input  logic [SEL_W-1:0] sel,
    output logic [TAG_W-1:0] tag
);
    // Ratio 256 * 4^sel is named by sel itself, zero-extended.
    always_comb begin
        tag = '0;
        tag[SEL_W-1:0] = sel;
    end
endmodule

// File: rtl/sr_shift_chan.sv
module sr_shift_chan
    import sr_pkg::*;
#(
    parameter int WIDTH = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] word_in,
    input  logic             sck,
    input  logic             rd_n,
    output logic             bit_out
);
    localparam int IW = $clog2(WIDTH);
    localparam logic [IW-1:0] TOP_IDX = IW'(WIDTH - 1);

    chan_state_e      state_q, state_d;
    logic [IW-1:0]    idx_q, idx_d;
    logic [WIDTH-1:0] word_q;
    logic             sck_q;
    logic             rise;

    assign rise = sck & ~sck_q & ~rd_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_SHIFT;
            idx_q   <= TOP_IDX;
            word_q  <= '0;
            sck_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            sck_q   <= sck;
            if (load) word_q <= word_in;
        end
    end

    // Transitions: reload, advance, finish, hold
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (load) begin
            state_d = CH_SHIFT;
            idx_d   = TOP_IDX;
        end else if (rise) begin
            unique case (state_q)
                CH_SHIFT: begin
                    idx_d = idx_q - 1'b1;
                    if (idx_q == IW'(1)) state_d = CH_LAST;
                end
                CH_LAST: idx_d = '0;
            endcase
        end
    end

    // Output
    always_comb begin
        bit_out = word_q[idx_q];
    end

    // R7
    load_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (idx_q == TOP_IDX) && (state_q == CH_SHIFT));
    // R8
    last_at_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_LAST) |-> (idx_q == '0));
    // R8
    last_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_LAST && !load) |=> (state_q == CH_LAST));
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && !load) |=> $stable(idx_q));
    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(word_q));
endmodule

// File: rtl/serial_result_port.sv
module serial_result_port
    import sr_pkg::*;
#(
    parameter bit SHARED_LINE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_a,
    input  logic [SEL_W-1:0]  df_sel,
    input  logic              load_a,
    input  logic              rd_a_n,
    input  logic              sck_a,
    input  logic [DIFF_W-1:0] diff_b,
    input  logic [CM_W-1:0]   cm_b,
    input  logic              load_b,
    input  logic              rd_b_n,
    input  logic              sck_b,
    output logic              sdo_a,
    output logic              sdo_a_en,
    output logic              sdo_b,
    output logic              sdo_b_en,
    output logic              conflict
);
    localparam int A_W = CODE_W + TAG_W;
    localparam int B_W = DIFF_W + CM_W;

    logic [TAG_W-1:0] tag;
    logic             a_bit, b_bit;

    sr_tag_enc #(.SEL_W(SEL_W), .TAG_W(TAG_W)) u_tag (
        .sel (df_sel),
        .tag (tag)
    );

    sr_shift_chan #(.WIDTH(A_W)) u_chan_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_a),
        .word_in ({code_a, tag}),
        .sck     (sck_a),
        .rd_n    (rd_a_n),
        .bit_out (a_bit)
    );

    sr_shift_chan #(.WIDTH(B_W)) u_chan_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_b),
        .word_in ({diff_b, cm_b}),
        .sck     (sck_b),
        .rd_n    (rd_b_n),
        .bit_out (b_bit)
    );

    assign conflict = ~rd_a_n & ~rd_b_n;
    assign sdo_a    = a_bit;
    assign sdo_a_en = ~rd_a_n;
    assign sdo_b    = b_bit;

    generate
        if (SHARED_LINE) begin : g_shared
            assign sdo_b_en = ~rd_b_n & rd_a_n;
            // R11
            a_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
                conflict |-> (sdo_a_en && !sdo_b_en));
        end else begin : g_split
            assign sdo_b_en = ~rd_b_n;
        end
    endgenerate

    // R2
    a_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_n |-> !sdo_a_en);
    // R2
    b_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b_n |-> !sdo_b_en);
endmodule

// File: tb/serial_result_port_test.sv
module serial_result_port_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] code_a = '0;
    logic [1:0]  df_sel = '0;
    logic        load_a = 0, rd_a_n = 1, sck_a = 0;
    logic [13:0] diff_b = '0;
    logic [7:0]  cm_b = '0;
    logic        load_b = 0, rd_b_n = 1, sck_b = 0;
    logic        sdo_a, sdo_a_en, sdo_b, sdo_b_en, conflict;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit ended = 0;

    serial_result_port uut (.*);

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !ended) begin
            ended = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic pulse_a();
        sck_a = 1; step(); sck_a = 0; step();
    endtask

    task automatic pulse_b();
        sck_b = 1; step(); sck_b = 0; step();
    endtask

    task automatic load_a_word(input logic [31:0] c, input logic [1:0] s);
        code_a = c; df_sel = s; load_a = 1; step();
        load_a = 0; code_a = ~c; df_sel = ~s;  // R5: later input changes ignored
    endtask

    task automatic load_b_word(input logic [13:0] d, input logic [7:0] m);
        diff_b = d; cm_b = m; load_b = 1; step();
        load_b = 0; diff_b = ~d; cm_b = ~m;
    endtask

    initial begin
        logic [39:0] fa;
        logic [21:0] fb;
        logic [31:0] codes [4];
        codes[0] = 32'h8000_0001; codes[1] = 32'hA5C3_0F71;
        codes[2] = 32'h7FFF_FFFF; codes[3] = 32'hFFFF_FFFF;

        step(); step(); rst_n = 1; step();
        // R1 / R2: reset state, enables off
        chk(sdo_a_en, 1'b0, "R2 a_en idle");
        chk(sdo_b_en, 1'b0, "R2 b_en idle");
        rd_a_n = 0; step();
        chk(sdo_a_en, 1'b1, "R2 a_en read");
        chk(sdo_a, 1'b0, "R1 a reset data");
        rd_a_n = 1; step();

        // R3 R4 R5 R7 R8: sweep all decimation selects
        for (int s = 0; s < 4; s++) begin
            load_a_word(codes[s], 2'(s));
            fa = {codes[s], 8'(s)};
            rd_a_n = 0; step();
            for (int i = 39; i >= 0; i--) begin
                chk(sdo_a, fa[i], (i < 8) ? "R4 tag bit" : "R3 code bit");
                pulse_a();
            end
            chk(sdo_a, fa[0], "R8 hold lsb");
            pulse_a();
            chk(sdo_a, fa[0], "R8 hold lsb again");
            rd_a_n = 1; step();
        end

        // R6 R10: split read with edges while disabled and a channel B reload
        load_a_word(32'h3C96_5A0F, 2'd2);
        fa = {32'h3C96_5A0F, 8'h02};
        rd_a_n = 0; step();
        for (int i = 39; i > 36; i--) begin
            chk(sdo_a, fa[i], "R6 burst one");
            pulse_a();
        end
        rd_a_n = 1; step();
        pulse_a(); pulse_a();  // R10: ignored
        load_b_word(14'h0155, 8'hAA);
        rd_a_n = 0; step();
        chk(sdo_a, fa[36], "R6 resume");
        chk(sdo_a, fa[36], "R10 no move while disabled");
        pulse_a();
        chk(sdo_a, fa[35], "R6 next after resume");

        // R12: load collides with enabled edge
        code_a = 32'h4000_0000; df_sel = 2'd1; load_a = 1; sck_a = 1; step();
        load_a = 0; sck_a = 0; step();
        chk(sdo_a, 1'b0, "R12 msb after collide");
        pulse_a();
        chk(sdo_a, 1'b1, "R12 second bit");
        rd_a_n = 1; step();

        // R9: channel B field order, several patterns
        for (int p = 0; p < 3; p++) begin
            logic [13:0] d; logic [7:0] m;
            d = (p == 0) ? 14'h3FFF : (p == 1) ? 14'h2001 : 14'h1555;
            m = (p == 0) ? 8'h00    : (p == 1) ? 8'h81    : 8'h3C;
            load_b_word(d, m);
            fb = {d, m};
            rd_b_n = 0; step();
            chk(sdo_b_en, 1'b1, "R2 b_en read");
            for (int i = 21; i >= 0; i--) begin
                chk(sdo_b, fb[i], (i < 8) ? "R9 cm bit" : "R9 diff bit");
                pulse_b();
            end
            chk(sdo_b, fb[0], "R8 b hold lsb");
            rd_b_n = 1; step();
        end

        // R7: reload mid-read rewinds channel B
        load_b_word(14'h2000, 8'h01);
        rd_b_n = 0; step();
        pulse_b(); pulse_b();
        load_b_word(14'h2000, 8'h01);
        chk(sdo_b, 1'b1, "R7 rewind to msb");

        // R11: both enabled
        rd_a_n = 0; step();
        chk(conflict, 1'b1, "R11 flag");
        chk(sdo_b_en, 1'b0, "R11 b withheld");
        chk(sdo_a_en, 1'b1, "R11 a driven");
        rd_a_n = 1; step();
        chk(conflict, 1'b0, "R11 flag clear");
        chk(sdo_b_en, 1'b1, "R11 b back");

        ended = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule